// File: doc/BRIEF.md
# Reloadable 8-bit timer and event counter

This block is an up-counter with a reload value, driven by a single clock. Software programs a mode, a run bit and an edge polarity through a small control register. It also sets a start value through a counter address that is shared in a particular way: a write stores the reload value, and a read returns the live count. In the counting modes the counter steps once per enabled tick. When it passes the all-ones value it takes the reload value, raises a sticky overflow flag and toggles a divided-frequency output.

Three modes count. Timer mode counts a selected internal tick. Event mode counts edges of an external pin. Pulse mode times how long the pin stays at one level, using the internal tick, and then stops itself. The external pin passes through a synchronizer. Each edge becomes a one-cycle pulse inside the clock domain. The internal tick is the free-running clock, a prescaled enable supplied from outside, or a strobe from a real-time clock. The overflow flag reaches the interrupt line only while the interrupt enable input is high.

No data stream crosses this block. All of its pins are plain control and status signals, so there is no valid/ready handshake and no back-pressure.

Top module: `evt_timer8`

## Requirements
- R1: After reset the count, the reload value, the control register (`ctl_rdata`), the overflow flag and the divider output are all 0.
- R2: Each enabled step adds one to the count. A step taken at the all-ones value loads the reload value instead, sets the overflow flag and counts as an overflow. This holds in every mode.
- R3: `src_sel` picks the internal tick. 0 means every cycle, 1 means `presc_en`, and 2 or 3 means `rtc_tick`. The tick drives timer mode and pulse mode.
- R4: Control bits [1:0] hold the mode. 00 holds the count even when running, 01 is event mode, 10 is timer mode and 11 is pulse mode. In event mode one step is taken per edge of `ext_pin` of the polarity set by control bit 2 (1 rising, 0 falling). Bit 3 is the run bit, and no step happens while it is 0.
- R5: `cnt_wr` always stores `cnt_wdata` as the reload value. While the run bit is 0 it also loads the count. While the run bit is 1 the count is untouched.
- R6: `cnt_rdata` shows the live count at all times. In a cycle with `cnt_rd` high no step is taken.
- R7: In pulse mode with the run bit set, the active edge of `ext_pin` starts a measurement. One step is taken per tick from that edge up to, but not including, the cycle in which the opposite edge arrives. With `src_sel` = 0, a level held for H cycles adds exactly H.
- R8: The opposite edge that ends a measurement clears the run bit (bit 3) by itself. The count then holds, and later edges are ignored until software sets the run bit again. In the other modes only a control write changes the run bit.
- R9: The overflow flag stays set until `irq_clr`. When `irq_clr` and an overflow happen in the same cycle, the clear wins.
- R10: `irq` is high exactly when the flag is set and `int_en` is high.
- R11: Each overflow toggles an internal divider bit. `pfd_out` shows that bit while `pfd_en_n` is 0 and is 0 while `pfd_en_n` is 1.
- R12: A change on `ext_pin` passes two synchronizer stages and an edge detector. It takes effect at the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_wr | input | 1 | Write strobe for the reload/count address |
| cnt_wdata | input | 8 | Value written to the reload register |
| cnt_rd | input | 1 | Read strobe; blocks the step in its cycle |
| cnt_rdata | output | 8 | Live count |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control value: [3] run, [2] rising edge, [1:0] mode |
| ctl_rdata | output | 4 | Control register contents |
| src_sel | input | 2 | Internal tick select |
| presc_en | input | 1 | Prescaled clock enable (one cycle in four) |
| rtc_tick | input | 1 | Real-time-clock timeout strobe |
| ext_pin | input | 1 | Asynchronous external input |
| int_en | input | 1 | Interrupt enable gate |
| irq_clr | input | 1 | Clears the overflow flag |
| pfd_en_n | input | 1 | Divider output enable, active low |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Gated interrupt request |
| pfd_out | output | 1 | Divided-frequency output |

## Verification
The bench uses the default parameters: an 8-bit count and a two-stage synchronizer. An 8-bit count wraps within a few hundred ticks, so random runs reach many reloads, clears that meet an overflow in the same cycle, and divider toggles. The short synchronizer makes the edge latency a fixed three cycles. Directed pulses can therefore be timed exactly, and the count from a pulse of known width can be predicted.

// File: rtl/evt_timer8_pkg.sv
package evt_timer8_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } tmr_mode_e;

  // run in bit 3, edge polarity in bit 2, mode in bits 1:0
  typedef struct packed {
    logic      run;
    logic      edge_rise;
    tmr_mode_e mode;
  } tmr_ctl_t;

  localparam int CTL_W = $bits(tmr_ctl_t);
endpackage

// File: rtl/evt_timer8_sync.sv
module evt_timer8_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] sh_q;
  logic         prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[TOP-1:0], pin};
      prev_q <= sh_q[TOP];
    end
  end

  assign rise = sh_q[TOP] & ~prev_q;
  assign fall = ~sh_q[TOP] & prev_q;
endmodule

// File: rtl/evt_timer8_tick.sv
module evt_timer8_tick (
  input  logic [1:0] src_sel,
  input  logic       presc_en,
  input  logic       rtc_tick,
  output logic       tick
);
  always_comb begin
    case (src_sel)
      2'd0:    tick = 1'b1;
      2'd1:    tick = presc_en;
      default: tick = rtc_tick;
    endcase
  end
endmodule

// File: rtl/evt_timer8_pwm.sv
module evt_timer8_pwm (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic act_edge,
  input  logic inact_edge,
  input  logic tick,
  output logic meas,
  output logic pulse_cnt,
  output logic pulse_done
);
  assign pulse_done = armed & meas & inact_edge;
  assign pulse_cnt  = armed & tick & (meas ? ~inact_edge : act_edge);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      meas <= 1'b0;
    else if (!armed)
      meas <= 1'b0;
    else if (!meas && act_edge)
      meas <= 1'b1;
    else if (pulse_done)
      meas <= 1'b0;
  end
endmodule

// File: rtl/evt_timer8.sv
module evt_timer8
  import evt_timer8_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             cnt_rd,
  output logic [CNT_W-1:0] cnt_rdata,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic [1:0]       src_sel,
  input  logic             presc_en,
  input  logic             rtc_tick,
  input  logic             ext_pin,
  input  logic             int_en,
  input  logic             irq_clr,
  input  logic             pfd_en_n,
  output logic             ovf_flag,
  output logic             irq,
  output logic             pfd_out
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  tmr_ctl_t         ctl_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] preload_q;
  logic             pfd_q;

  logic pin_rise, pin_fall, act_edge, inact_edge;
  logic tick, meas, pulse_cnt, pulse_done, armed;
  logic step, ovf;

  evt_timer8_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (ext_pin),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  evt_timer8_tick tick_i (
    .src_sel (src_sel),
    .presc_en(presc_en),
    .rtc_tick(rtc_tick),
    .tick    (tick)
  );

  assign act_edge   = ctl_q.edge_rise ? pin_rise : pin_fall;
  assign inact_edge = ctl_q.edge_rise ? pin_fall : pin_rise;
  assign armed      = ctl_q.run && (ctl_q.mode == MODE_PULSE);

  evt_timer8_pwm pwm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .armed     (armed),
    .act_edge  (act_edge),
    .inact_edge(inact_edge),
    .tick      (tick),
    .meas      (meas),
    .pulse_cnt (pulse_cnt),
    .pulse_done(pulse_done)
  );

  // step selection per mode; a read blocks the step
  always_comb begin
    step = 1'b0;
    if (ctl_q.run && !cnt_rd) begin
      case (ctl_q.mode)
        MODE_EVENT: step = act_edge;
        MODE_TIMER: step = tick;
        MODE_PULSE: step = pulse_cnt;
        default:    step = 1'b0;
      endcase
    end
  end

  assign ovf = step && (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_wr) begin
      ctl_q <= tmr_ctl_t'(ctl_wdata);
    end else if (pulse_done) begin
      ctl_q.run <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preload_q <= '0;
      cnt_q     <= '0;
    end else begin
      if (cnt_wr)
        preload_q <= cnt_wdata;
      if (cnt_wr && !ctl_q.run)
        cnt_q <= cnt_wdata;
      else if (ovf)
        cnt_q <= preload_q;
      else if (step)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      pfd_q    <= 1'b0;
    end else begin
      if (irq_clr)
        ovf_flag <= 1'b0;
      else if (ovf)
        ovf_flag <= 1'b1;
      if (ovf)
        pfd_q <= ~pfd_q;
    end
  end

  assign cnt_rdata = cnt_q;
  assign ctl_rdata = ctl_q;
  assign irq       = ovf_flag & int_en;
  assign pfd_out   = pfd_q & ~pfd_en_n;
endmodule

// File: rtl/evt_timer8_chk.sv
module evt_timer8_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic             cnt_rd,
  input logic [CNT_W-1:0] cnt_rdata,
  input logic             ctl_wr,
  input logic [3:0]       ctl_rdata,
  input logic             int_en,
  input logic             irq_clr,
  input logic             ovf_flag,
  input logic             irq,
  input logic [CNT_W-1:0] preload_q
);
  localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> !ovf_flag); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !irq_clr) |=> ovf_flag); // R9
  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_rdata[3] && !cnt_wr) |=> $stable(cnt_rdata)); // R4
  AST_STOPPED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && !ctl_rdata[3]) |=> (cnt_rdata == $past(cnt_wdata))); // R5
  AST_READ_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rd && ctl_rdata[3]) |=> $stable(cnt_rdata)); // R6
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctl_rdata[3]) && ($past(cnt_rdata) == ALL1) && (cnt_rdata != ALL1))
      |-> (cnt_rdata == $past(preload_q))); // R2
  AST_SELF_STOP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ctl_rdata[3]) && !$past(ctl_wr)) |-> ($past(ctl_rdata[1:0]) == 2'b11)); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |-> !irq); // R10
endmodule

bind evt_timer8 evt_timer8_chk #(.CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_wr   (cnt_wr),
  .cnt_wdata(cnt_wdata),
  .cnt_rd   (cnt_rd),
  .cnt_rdata(cnt_rdata),
  .ctl_wr   (ctl_wr),
  .ctl_rdata(ctl_rdata),
  .int_en   (int_en),
  .irq_clr  (irq_clr),
  .ovf_flag (ovf_flag),
  .irq      (irq),
  .preload_q(preload_q)
);

// File: tb/evt_timer8_tb_top.sv
`timescale 1ns/1ps
module evt_timer8_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_wr = 0, cnt_rd = 0, ctl_wr = 0;
  logic [7:0] cnt_wdata = 0;
  logic [3:0] ctl_wdata = 0;
  logic [1:0] src_sel = 0;
  logic       presc_en = 0, rtc_tick = 0, ext_pin = 0;
  logic       int_en = 0, irq_clr = 0, pfd_en_n = 0;
  logic [7:0] cnt_rdata;
  logic [3:0] ctl_rdata;
  logic       ovf_flag, irq, pfd_out;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  evt_timer8 dut_i (.*);

  // ---------------- reference model, built from the requirements ----------
  logic [7:0] m_cnt, m_pre;
  logic [3:0] m_ctl;
  logic       m_meas, m_flag, m_pfd, m_prev;
  logic [1:0] m_sh;

  function automatic logic f_tick(logic [1:0] s, logic p, logic r);
    return (s == 2'd0) ? 1'b1 : (s == 2'd1) ? p : r;  // R3
  endfunction

  function automatic logic f_step(logic [3:0] c, logic meas, logic act,
                                  logic inact, logic tk, logic rd);
    if (!c[3] || rd) return 1'b0;
    case (c[1:0])
      2'b01:   return act;
      2'b10:   return tk;
      2'b11:   return tk && (meas ? !inact : act);
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_ctl = 0; m_meas = 0;
      m_flag = 0; m_pfd = 0; m_prev = 0; m_sh = 0;
    end else begin
      logic rise, fall, act, inact, tk, armed, pdone, st, ovf;
      rise  = m_sh[1] & ~m_prev;
      fall  = ~m_sh[1] & m_prev;
      act   = m_ctl[2] ? rise : fall;
      inact = m_ctl[2] ? fall : rise;
      tk    = f_tick(src_sel, presc_en, rtc_tick);
      armed = m_ctl[3] && (m_ctl[1:0] == 2'b11);
      pdone = armed && m_meas && inact;
      st    = f_step(m_ctl, m_meas, act, inact, tk, cnt_rd);
      ovf   = st && (m_cnt == 8'hFF);
      if (cnt_wr && !m_ctl[3]) m_cnt = cnt_wdata;
      else if (ovf)            m_cnt = m_pre;
      else if (st)             m_cnt = m_cnt + 8'd1;
      if (cnt_wr) m_pre = cnt_wdata;
      if (!armed)                m_meas = 1'b0;
      else if (!m_meas && act)   m_meas = 1'b1;
      else if (pdone)            m_meas = 1'b0;
      if (ctl_wr)      m_ctl = ctl_wdata;
      else if (pdone)  m_ctl[3] = 1'b0;
      if (irq_clr)  m_flag = 1'b0;
      else if (ovf) m_flag = 1'b1;
      if (ovf) m_pfd = ~m_pfd;
      m_prev = m_sh[1];
      m_sh   = {m_sh[0], ext_pin};
    end
  end

  // ---------------- checking helpers --------------------------------------
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    chk("R6 live count vs model", cnt_rdata, m_cnt);
    chk("R9 flag vs model", ovf_flag, m_flag);
    chk("R10 irq gate", irq, m_flag & int_en);
    chk("R11 divider output", pfd_out, m_pfd & ~pfd_en_n);
    chk("R8 control vs model", ctl_rdata, m_ctl);
    cnt_wr = 0; cnt_rd = 0; ctl_wr = 0; irq_clr = 0;
  endtask

  task automatic wr_ctl(logic [3:0] v);
    ctl_wr = 1; ctl_wdata = v; cyc();
  endtask

  task automatic wr_cnt(logic [7:0] v);
    cnt_wr = 1; cnt_wdata = v; cyc();
  endtask

  // ---------------- stimulus ----------------------------------------------
  initial begin
    logic [7:0] c;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc();
    // R1 reset state
    chk("R1 count", cnt_rdata, 8'h00);
    chk("R1 control", ctl_rdata, 4'h0);
    chk("R1 flag", ovf_flag, 1'b0);
    chk("R1 divider", pfd_out, 1'b0);

    // R5 stopped write loads the count
    wr_cnt(8'hF0);
    chk("R5 stopped load", cnt_rdata, 8'hF0);
    // R5 running write touches reload only
    wr_ctl(4'b1010);                   // run, timer, every cycle
    wr_cnt(8'h80);
    chk("R5 running write ignored by count", cnt_rdata, 8'hF1);
    for (int i = 0; i < 40 && !ovf_flag; i++) cyc();
    chk("R2 reload after wrap", cnt_rdata, 8'h80);
    chk("R2 flag set", ovf_flag, 1'b1);
    chk("R11 divider toggled", pfd_out, 1'b1);

    // R6 read blocks the step
    c = cnt_rdata;
    cnt_rd = 1; cyc();
    chk("R6 blocked step", cnt_rdata, c);
    cyc();
    chk("R6 step resumes", cnt_rdata, c + 8'd1);

    // R10 interrupt gating, R9 clear, R11 output gating
    int_en = 0; cyc();
    chk("R10 masked irq", irq, 1'b0);
    int_en = 1; cyc();
    chk("R10 unmasked irq", irq, 1'b1);
    irq_clr = 1; cyc();
    chk("R9 clear", ovf_flag, 1'b0);
    pfd_en_n = 1; cyc();
    chk("R11 output disabled", pfd_out, 1'b0);
    pfd_en_n = 0;

    // R4 mode 00 holds while running
    wr_ctl(4'b1000);
    c = cnt_rdata;
    cyc(); cyc();
    chk("R4 hold mode", cnt_rdata, c);

    // R9 clear wins over same-cycle overflow
    wr_ctl(4'b0000);
    wr_cnt(8'hFE);
    wr_ctl(4'b1010);                   // edge A: run set
    cyc();                             // edge B: FE->FF
    irq_clr = 1; cyc();                // edge C: overflow and clear
    chk("R9 clear beats overflow", ovf_flag, 1'b0);
    chk("R2 reload on wrap", cnt_rdata, 8'hFE);
    cyc(); cyc();
    chk("R9 later overflow sets", ovf_flag, 1'b1);

    // R3 prescaled and rtc sources
    wr_ctl(4'b0000);
    wr_cnt(8'h00);
    src_sel = 2'd1;
    wr_ctl(4'b1010);
    for (int i = 0; i < 20; i++) begin presc_en = (i % 4 == 0); cyc(); end
    presc_en = 0; cyc();
    chk("R3 prescaled ticks", cnt_rdata, 8'd5);
    src_sel = 2'd2;
    for (int i = 0; i < 9; i++) begin rtc_tick = (i % 3 == 0); cyc(); end
    rtc_tick = 0; cyc();
    chk("R3 rtc ticks", cnt_rdata, 8'd8);
    src_sel = 2'd0;

    // R4 and R12 event mode, rising edges
    wr_ctl(4'b0000);
    wr_cnt(8'h00);
    ext_pin = 0;
    wr_ctl(4'b1101);
    for (int k = 0; k < 3; k++) begin
      ext_pin = 1; repeat (4) cyc();
      ext_pin = 0; repeat (4) cyc();
    end
    chk("R4 event count", cnt_rdata, 8'd3);
    ext_pin = 1; cyc(); cyc();
    chk("R12 edge not yet seen", cnt_rdata, 8'd3);
    cyc();
    chk("R12 edge counted on third edge", cnt_rdata, 8'd4);
    ext_pin = 0; repeat (4) cyc();

    // R7 and R8 pulse measurement
    wr_ctl(4'b0000);
    wr_cnt(8'h05);
    wr_ctl(4'b1111);
    repeat (3) cyc();
    chk("R7 idle before edge", cnt_rdata, 8'h05);
    ext_pin = 1; repeat (10) cyc();
    ext_pin = 0; repeat (5) cyc();
    chk("R7 pulse width", cnt_rdata, 8'h0F);
    chk("R8 run self-cleared", ctl_rdata[3], 1'b0);
    ext_pin = 1; repeat (5) cyc();
    ext_pin = 0; repeat (5) cyc();
    chk("R8 later edges ignored", cnt_rdata, 8'h0F);

    // R8 timer mode keeps run bit; random mix against the model
    wr_ctl(4'b1010);
    repeat (300) cyc();
    chk("R8 timer run kept", ctl_rdata[3], 1'b1);
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(5) == 0) ext_pin = ~ext_pin;
      presc_en = (i % 4 == 0);
      rtc_tick = ($urandom_range(9) == 0);
      if ($urandom_range(39) == 0) begin cnt_wr = 1; cnt_wdata = 8'($urandom); end
      if ($urandom_range(29) == 0) begin
        ctl_wr = 1; ctl_wdata = 4'($urandom) | ($urandom_range(3) != 0 ? 4'h8 : 4'h0);
      end
      cnt_rd  = ($urandom_range(7) == 0);
      irq_clr = ($urandom_range(19) == 0);
      if ($urandom_range(99) == 0) src_sel = 2'($urandom);
      if ($urandom_range(49) == 0) int_en = ~int_en;
      if ($urandom_range(59) == 0) pfd_en_n = ~pfd_en_n;
      cyc();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule